// File: doc/BRIEF.md
# NAND Block Write-Protect Guard

This unit sits beside a NAND flash controller's operation sequencer. Before a program or erase is issued to the flash, it decides whether the target block may be modified. Software sets up a small set of block ranges that are allowed to change, each given as an inclusive first and last block. It then writes a protection command that opens the guard, closes it, or freezes the whole setup until the next reset. The sequencer offers each pending program or erase block number to the unit. One clock later it receives a permit or a deny.

A separate configuration bit controls the controller's internal buffer RAM. While the bit is clear, host write strobes into the buffer are blocked. Two status outputs report the unit's state. One gives the protection mode. The other is a sticky flag that is set the first time any operation is refused.

Register writes use a simple strobe, address and data port. Window n has its first-block register at address 2n and its last-block register at address 2n+1. The protection command follows the last window. The configuration register comes after the command.

Top module: `nand_wp_guard`

## Requirements
- R1: After a synchronous active-low reset, `wp_mode` is 2'b00 (locked, not frozen), `deny_sticky` is 0, `resp_valid` is 0 and the buffer write gate is closed.
- R2: While `wp_mode[0]` is 0 (locked), every offered operation is answered with `resp_permit` = 0.
- R3: While unlocked, an operation is permitted exactly when its block B satisfies first <= B <= last for at least one of the NUM_WIN windows. A window whose first block exceeds its last block covers no block.
- R4: Each cycle with `op_valid` high produces `resp_valid` high in the next cycle, and `resp_valid` is low otherwise. The decision uses the protection state held before any register write in the same cycle.
- R5: The protection command register sits at address 2*NUM_WIN, and its bits are read with a fixed priority. Bit0 (freeze) wins over bit1 (lock), which wins over bit2 (unlock). A written value with none of these bits set changes nothing. Unlock sets `wp_mode[0]` and lock clears it.
- R6: The freeze command sets `wp_mode[1]` and keeps the current locked or unlocked state in `wp_mode[0]`. From then until reset, writes to the window registers and to the command register have no effect.
- R7: `deny_sticky` goes high in the cycle a deny is reported on `resp_valid`/`resp_permit`, and it stays high until reset.
- R8: The configuration register sits at address 2*NUM_WIN+1. Its bit1 opens the buffer gate, so `buf_we_out` = `host_buf_we` AND that bit. This register stays writable after freeze.
- R9: Reset clears every window to first = last = 0. An unlock alone therefore permits block 0 and denies every other block.
- R10: Window 0 set to 0x0000..0xFFFF followed by an unlock permits every 16-bit block number, including both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | BLK_W (16) | Register write data |
| op_valid | input | 1 | A program/erase target is offered this cycle |
| op_block | input | BLK_W (16) | Target block number of the offered operation |
| resp_valid | output | 1 | Decision for the operation offered one cycle earlier |
| resp_permit | output | 1 | 1 = permitted, 0 = denied (valid with resp_valid) |
| host_buf_we | input | 1 | Host write strobe toward buffer RAM |
| buf_we_out | output | 1 | Gated write strobe to buffer RAM |
| wp_mode | output | 2 | bit1 = frozen, bit0 = unlocked |
| deny_sticky | output | 1 | Set on any denied operation, cleared by reset |

## Verification
The hardest condition to reach is freeze. Once frozen, the only way back is reset, so the sequence is ordered so that every unlocked and locked case runs before the freeze. Freeze is also issued together with lock and unlock in one written value, which tests the priority and the freeze at once. After the freeze, the bench writes to a window and to the command register. It then offers blocks that would be decided differently if those writes had taken effect. A second reset then proves the windows went back to zero. A separate cycle combines an operation with a lock write, which shows that the decision uses the state held before the write.

// File: rtl/nand_wp_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions of the block write-protect guard.
// Assumes command bits are read with a fixed priority: freeze, lock, unlock.
package nand_wp_pkg;

    typedef enum logic [1:0] {
        WPC_NONE   = 2'd0,
        WPC_FREEZE = 2'd1,
        WPC_LOCK   = 2'd2,
        WPC_OPEN   = 2'd3
    } wp_cmd_e;

    localparam int CMD_FREEZE_BIT = 0;
    localparam int CMD_LOCK_BIT   = 1;
    localparam int CMD_OPEN_BIT   = 2;
    localparam int CFG_BUF_BIT    = 1;

    // Turn a written command value into one action, highest priority first.
    function automatic wp_cmd_e decode_cmd(input logic [2:0] val);
        if (val[CMD_FREEZE_BIT])    return WPC_FREEZE;
        else if (val[CMD_LOCK_BIT]) return WPC_LOCK;
        else if (val[CMD_OPEN_BIT]) return WPC_OPEN;
        else                        return WPC_NONE;
    endfunction

endpackage

// File: rtl/nand_wp_window.sv
`timescale 1ns/1ps
// Module: one inclusive block range (first..last) with its hit comparator.
// Assumes the writes are already address-decoded by the parent. While
// `frozen` is high both bounds ignore writes. Reset clears both bounds to zero.
module nand_wp_window #(
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen,
    input  logic             wr_first,
    input  logic             wr_last,
    input  logic [BLK_W-1:0] wdata,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);

    logic [BLK_W-1:0] first_q;
    logic [BLK_W-1:0] last_q;

    // Bound registers: load on a decoded write unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
        end else if (!frozen) begin
            if (wr_first) first_q <= wdata;
            if (wr_last)  last_q  <= wdata;
        end
    end

    // Inclusive range compare: an inverted range matches nothing.
    always_comb begin
        hit = (blk >= first_q) && (blk <= last_q);
    end

    // R6: bounds cannot move once frozen
    a_r6_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> ($stable(first_q) && $stable(last_q)));

endmodule

// File: rtl/nand_wp_ctrl.sv
`timescale 1ns/1ps
// Module: protection mode controller (locked / unlocked, plus freeze).
// Assumes cmd_we is already decoded for the command address. Freezing keeps
// the current open/closed state and blocks every later command until reset.
module nand_wp_ctrl
    import nand_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [2:0] cmd_val,
    output logic       unlocked,
    output logic       frozen
);

    wp_cmd_e cmd;

    // Pick one action from the written bits by priority.
    always_comb begin
        cmd = decode_cmd(cmd_val);
    end

    // Mode state: reset locked, commands take effect only while not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            frozen   <= 1'b0;
        end else if (cmd_we && !frozen) begin
            case (cmd)
                WPC_FREEZE: frozen   <= 1'b1;
                WPC_LOCK:   unlocked <= 1'b0;
                WPC_OPEN:   unlocked <= 1'b1;
                default:    ;
            endcase
        end
    end

    // R6: freeze persists until reset
    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> frozen);

    // R6: open/closed state cannot change after freeze
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(unlocked));

endmodule

// File: rtl/nand_wp_guard.sv
`timescale 1ns/1ps
// Module: top of the NAND block write-protect guard.
// Decodes register writes into NUM_WIN range windows, the mode controller and
// the buffer-gate configuration bit. It answers each offered program or erase
// block one cycle later and keeps a sticky deny flag.
// Assumes: window n first at address 2n, last at 2n+1; command at 2*NUM_WIN;
// configuration at 2*NUM_WIN+1.
module nand_wp_guard
    import nand_wp_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int BLK_W   = 16,
    localparam int ADDR_W = $clog2(2 * NUM_WIN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BLK_W-1:0]  reg_wdata,
    input  logic              op_valid,
    input  logic [BLK_W-1:0]  op_block,
    output logic              resp_valid,
    output logic              resp_permit,
    input  logic              host_buf_we,
    output logic              buf_we_out,
    output logic [1:0]        wp_mode,
    output logic              deny_sticky
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(2 * NUM_WIN);
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(2 * NUM_WIN + 1);

    logic [NUM_WIN-1:0] hit_vec;
    logic               unlocked;
    logic               frozen;
    logic               permit_now;
    logic               cfg_buf_q;
    logic               resp_valid_q;
    logic               resp_permit_q;
    logic               sticky_q;

    // One window instance per range, each with its own address decode.
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic wr_first;
        logic wr_last;
        assign wr_first = reg_we && (reg_addr == ADDR_W'(2 * i));
        assign wr_last  = reg_we && (reg_addr == ADDR_W'(2 * i + 1));
        nand_wp_window #(.BLK_W(BLK_W)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .frozen   (frozen),
            .wr_first (wr_first),
            .wr_last  (wr_last),
            .wdata    (reg_wdata),
            .blk      (op_block),
            .hit      (hit_vec[i])
        );
    end

    nand_wp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (reg_we && (reg_addr == CMD_ADDR)),
        .cmd_val  (reg_wdata[2:0]),
        .unlocked (unlocked),
        .frozen   (frozen)
    );

    // Decision: open mode and at least one window covering the block.
    always_comb begin
        permit_now = unlocked && (|hit_vec);
    end

    // Response register: one-cycle answer to each offered operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q  <= 1'b0;
            resp_permit_q <= 1'b0;
        end else begin
            resp_valid_q  <= op_valid;
            resp_permit_q <= op_valid && permit_now;
        end
    end

    // Sticky deny flag: set by any refused operation, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)                       sticky_q <= 1'b0;
        else if (op_valid && !permit_now) sticky_q <= 1'b1;
    end

    // Buffer-gate configuration bit: stays writable regardless of freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_buf_q <= 1'b0;
        else if (reg_we && reg_addr == CFG_ADDR) cfg_buf_q <= reg_wdata[CFG_BUF_BIT];
    end

    // Output wiring.
    always_comb begin
        buf_we_out  = host_buf_we & cfg_buf_q;
        resp_valid  = resp_valid_q;
        resp_permit = resp_permit_q;
        wp_mode     = {frozen, unlocked};
        deny_sticky = sticky_q;
    end

    // R4: every offered operation is answered the next cycle
    a_r4_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> resp_valid);

    // R4: no answer without an offer
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !resp_valid);

    // R2: locked mode refuses everything
    a_r2_locked_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wp_mode[0]) |=> !resp_permit);

    // R7: the deny flag never drops without reset
    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        deny_sticky |=> deny_sticky);

    // R7: a reported deny is always reflected in the flag
    a_r7_deny_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_permit) |-> deny_sticky);

endmodule

// File: tb/tb_nand_wp_guard.sv
`timescale 1ns/1ps
// Scoreboard bench: op tasks push expected decisions, a monitor pops and compares.
module tb_nand_wp_guard;

    localparam int NUM_WIN = 4;
    localparam int BLK_W   = 16;
    localparam int ADDR_W  = 4;
    localparam logic [ADDR_W-1:0] A_CMD = 4'd8;
    localparam logic [ADDR_W-1:0] A_CFG = 4'd9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [BLK_W-1:0]  reg_wdata = '0;
    logic              op_valid = 1'b0;
    logic [BLK_W-1:0]  op_block = '0;
    logic              resp_valid;
    logic              resp_permit;
    logic              host_buf_we = 1'b0;
    logic              buf_we_out;
    logic [1:0]        wp_mode;
    logic              deny_sticky;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    nand_wp_guard #(.NUM_WIN(NUM_WIN), .BLK_W(BLK_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .op_valid(op_valid), .op_block(op_block),
        .resp_valid(resp_valid), .resp_permit(resp_permit),
        .host_buf_we(host_buf_we), .buf_we_out(buf_we_out),
        .wp_mode(wp_mode), .deny_sticky(deny_sticky)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each decision with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && resp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R4: actual unexpected response expected none");
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, {31'd0, resp_permit}, {31'd0, e});
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [BLK_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic op(input logic [BLK_W-1:0] b, input bit exp, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_block = b;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        host_buf_we = 1'b1;
        chk("R1 mode", {30'd0, wp_mode}, 32'd0);
        chk("R1 sticky", {31'd0, deny_sticky}, 32'd0);
        chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
        chk("R1 gate", {31'd0, buf_we_out}, 32'd0);
        // R2 locked denies
        op(16'h0000, 1'b0, "R2 locked blk0");
        chk("R7 sticky set", {31'd0, deny_sticky}, 32'd1);
        // R5 unlock, R9 zeroed windows
        wr(A_CMD, 16'h0004);
        chk("R5 unlock mode", {30'd0, wp_mode}, 32'd1);
        op(16'h0000, 1'b1, "R9 blk0 permitted");
        op(16'h0001, 1'b0, "R9 blk1 denied");
        // R3 windows
        wr(4'd2, 16'h0100); wr(4'd3, 16'h01FF);
        wr(4'd4, 16'h8000); wr(4'd5, 16'h8000);
        wr(4'd6, 16'h0500); wr(4'd7, 16'h0400);
        op(16'h00FF, 1'b0, "R3 below win1");
        op(16'h0100, 1'b1, "R3 win1 first");
        op(16'h01FF, 1'b1, "R3 win1 last");
        op(16'h0200, 1'b0, "R3 above win1");
        op(16'h8000, 1'b1, "R3 single-block win2");
        op(16'h8001, 1'b0, "R3 past win2");
        op(16'h0450, 1'b0, "R3 inverted win3");
        // R5 priority: lock beats unlock, empty value ignored
        wr(A_CMD, 16'h0006);
        chk("R5 lock over unlock", {30'd0, wp_mode}, 32'd0);
        op(16'h0100, 1'b0, "R2 locked in window");
        wr(A_CMD, 16'h0000);
        chk("R5 empty command", {30'd0, wp_mode}, 32'd0);
        wr(A_CMD, 16'h0004);
        // R4 decision uses state before same-cycle write
        @(negedge clk);
        op_valid = 1'b1; op_block = 16'h0100;
        reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 16'h0002;
        exp_q.push_back(1'b1); tag_q.push_back("R4 pre-write state");
        @(negedge clk);
        op_valid = 1'b0; reg_we = 1'b0;
        chk("R4 lock applied", {30'd0, wp_mode}, 32'd0);
        op(16'h0100, 1'b0, "R4 after lock");
        // R10 full window
        wr(4'd0, 16'h0000); wr(4'd1, 16'hFFFF); wr(A_CMD, 16'h0004);
        op(16'hFFFF, 1'b1, "R10 top block");
        op(16'h1234, 1'b1, "R10 mid block");
        // R6 freeze wins over all bits, keeps unlocked
        wr(A_CMD, 16'h0007);
        chk("R6 frozen open", {30'd0, wp_mode}, 32'd3);
        wr(A_CMD, 16'h0002);
        chk("R6 command ignored", {30'd0, wp_mode}, 32'd3);
        wr(4'd1, 16'h0000);
        op(16'h1234, 1'b1, "R6 window write ignored");
        // R8 config still writable after freeze
        wr(A_CFG, 16'h0002);
        chk("R8 gate open", {31'd0, buf_we_out}, 32'd1);
        host_buf_we = 1'b0;
        #1 chk("R8 gate follows host", {31'd0, buf_we_out}, 32'd0);
        host_buf_we = 1'b1;
        wr(A_CFG, 16'h0000);
        chk("R8 gate closed", {31'd0, buf_we_out}, 32'd0);
        chk("R7 sticky held", {31'd0, deny_sticky}, 32'd1);
        // R9 second reset clears windows; R6 freeze while locked
        do_reset();
        chk("R1 mode again", {30'd0, wp_mode}, 32'd0);
        chk("R1 sticky again", {31'd0, deny_sticky}, 32'd0);
        wr(A_CMD, 16'h0004);
        op(16'h1234, 1'b0, "R9 window cleared");
        op(16'h0000, 1'b1, "R9 blk0 after reset");
        wr(A_CMD, 16'h0002);
        wr(A_CMD, 16'h0001);
        chk("R6 frozen locked", {30'd0, wp_mode}, 32'd2);
        wr(A_CMD, 16'h0004);
        op(16'h0000, 1'b0, "R6 unlock ignored");
        repeat (3) @(negedge clk);
        chk("R4 queue drained", exp_q.size(), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hang counts as one failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule